// File: doc/BRIEF.md
# Down-counting periodic timer

A memory-mapped 16-bit timer that counts down from a software-written start value. Each count step happens on a single-cycle enable pulse, not on a derived clock. A free-running divider makes one pulse train at a slow rate and another makes one at a fast rate, both from the one reference clock. A control field selects the pulse train, turns counting on or off, and chooses what happens when the counter runs out. In periodic mode the counter restarts from the stored start value. In free mode it wraps to all ones.

When the counter steps past zero, a sticky interrupt flag is set. The flag stays high until software writes anything to the clear register. Software measures elapsed time by reading the live counter and subtracting it from the start value. Writes and reads use separate strobes and addresses, so a read and a write can happen in the same cycle. Read data is registered.

Top module: `periodic_down_timer`

## Requirements
- R1: After reset, the counter, start value and control field are zero, `irq` is low, and `rd_data` is zero.
- R2: Word addresses are 0 for the start value (read/write), 1 for the live counter (read-only), 2 for control (read/write) and 3 for interrupt clear (write-only, reads zero). `rd_data` holds the selected register one cycle after `rd_en`. Bits above the register width read as zero.
- R3: Control bit 0 is run. Bit 1 selects the mode: 1 is periodic, 0 is free. Bit 2 selects the rate: 1 is fast, 0 is slow. Only these three bits are stored.
- R4: The slow count enable pulses once every SLOW_DIV clocks and the fast one once every FAST_DIV clocks. Each pulse lasts one cycle, and both dividers run freely from reset.
- R5: While run is 1, each selected pulse lowers the counter by one. With start value N, underflows repeat every (N+1) pulses.
- R6: In periodic mode, a pulse taken at zero reloads the counter from the start value.
- R7: In free mode, a pulse taken at zero sets the counter to 0xFFFF.
- R8: The pulse taken at zero sets `irq` on the same clock edge that updates the counter. `irq` then stays high.
- R9: Any write to address 3 clears `irq`, whatever the data. If an underflow happens on the same edge, `irq` stays set.
- R10: Writing the start value while run is 0 also loads the counter. A control write that raises run from 0 restarts the counter from the start value.
- R11: While run is 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Sticky underflow interrupt |

## Verification
A write takes effect on the edge that captures it. Read data appears on the edge after the read is captured. `irq` rises on the same edge as the underflowing pulse and falls on the edge that captures a clear. The bench drives on falling edges and samples one falling edge after each capturing edge. It reads the counter and clears the flag in the same cycle in which `irq` is first seen, so even at the fastest rate the next underflow cannot coincide with that access. The repeat period is measured between two successive underflows, which removes the unknown divider phase at enable, and is compared with (N+1) times the divider. The set-versus-clear case places a clear exactly on the known next underflow edge of a one-pulse period.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned REG_LOAD  = 0;
  localparam int unsigned REG_VALUE = 1;
  localparam int unsigned REG_CTRL  = 2;
  localparam int unsigned REG_CLEAR = 3;
  localparam int unsigned CTRL_W    = 3;

  typedef struct packed {
    logic fast;
    logic periodic;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_tick_div.sv
module tmr_tick_div #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             periodic,
  input  logic             tick,
  input  logic             preload,
  input  logic [CNT_W-1:0] preload_val,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);
  logic [CNT_W-1:0] count_q;
  logic             step;

  assign step      = run && tick;
  assign underflow = step && (count_q == '0);
  assign count     = count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else if (preload) count_q <= preload_val;
    else if (restart) count_q <= load_val;
    else if (step) begin
      if (count_q == '0) count_q <= periodic ? load_val : '1;
      else count_q <= count_q - 1'b1;
    end
  end

  p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
    (step && count_q != '0) |=> count_q == ($past(count_q) - CNT_W'(1)));
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (step && count_q == '0 && periodic) |=> count_q == $past(load_val));
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (step && count_q == '0 && !periodic) |=> count_q == '1);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!run && !preload && !restart) |=> $stable(count_q));
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign irq = flag_q;

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    set |=> irq);
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !irq);
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq);
endmodule

// File: rtl/periodic_down_timer.sv
module periodic_down_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned SLOW_DIV = 145,
  parameter int unsigned FAST_DIV = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int unsigned NRATES = 2;

  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] count;
  logic [NRATES-1:0] ticks;
  logic             tick_sel;
  logic             underflow;
  logic             wr_load, wr_ctrl, wr_clear;
  logic             preload, restart;
  tmr_ctrl_t        ctrl_new;
  logic [DATA_W-1:0] rd_data_q;

  genvar g;
  generate
    for (g = 0; g < NRATES; g++) begin : g_rate
      tmr_tick_div #(.DIV(g == 0 ? SLOW_DIV : FAST_DIV)) i_div (
        .clk (clk),
        .rst (rst),
        .tick(ticks[g])
      );
    end
  endgenerate

  assign tick_sel = ctrl_q.fast ? ticks[1] : ticks[0];

  assign wr_load  = wr_en && (wr_addr == ADDR_W'(REG_LOAD));
  assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
  assign wr_clear = wr_en && (wr_addr == ADDR_W'(REG_CLEAR));
  assign ctrl_new = tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
  assign preload  = wr_load && !ctrl_q.run;
  assign restart  = wr_ctrl && ctrl_new.run && !ctrl_q.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (wr_load) load_q <= wr_data[CNT_W-1:0];
    end
  end

  tmr_counter #(.CNT_W(CNT_W)) i_counter (
    .clk        (clk),
    .rst        (rst),
    .run        (ctrl_q.run),
    .periodic   (ctrl_q.periodic),
    .tick       (tick_sel),
    .preload    (preload),
    .preload_val(wr_data[CNT_W-1:0]),
    .restart    (restart),
    .load_val   (load_q),
    .count      (count),
    .underflow  (underflow)
  );

  tmr_irq_flag i_irq (
    .clk(clk),
    .rst(rst),
    .set(underflow),
    .clr(wr_clear),
    .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data_q <= '0;
    else if (rd_en) begin
      case (rd_addr)
        ADDR_W'(REG_LOAD):  rd_data_q <= DATA_W'(load_q);
        ADDR_W'(REG_VALUE): rd_data_q <= DATA_W'(count);
        ADDR_W'(REG_CTRL):  rd_data_q <= DATA_W'(ctrl_q);
        default:            rd_data_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_data_q;

  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    restart |=> count == $past(load_q));
  p_preload_r10: assert property (@(posedge clk) disable iff (rst)
    preload |=> count == $past(wr_data[CNT_W-1:0]));
endmodule

// File: tb/test_periodic_down_timer.sv
module test_periodic_down_timer;
  localparam int SDIV = 8;
  localparam int FDIV = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  periodic_down_timer #(.SLOW_DIV(SDIV), .FAST_DIV(FDIV)) i_periodic_down_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic rd_and_clear(output logic [31:0] v);
    rd_en = 1'b1; rd_addr = 2'd1;
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'h5A5A_0001;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wait_irq(output int t);
    t = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) begin t = cyc; break; end
    end
    if (t < 0) chk("R8 irq timeout", 32'd0, 32'd1);
  endtask

  initial begin
    logic [31:0] v, v2;
    int ta, tb, div;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 rd_data after reset", rd_data, 32'd0);
    rd(2'd0, v); chk("R1 start value reset", v, 32'd0);
    rd(2'd1, v); chk("R1 counter reset", v, 32'd0);
    rd(2'd2, v); chk("R1 control reset", v, 32'd0);

    wr(2'd2, 32'hFFFF_FFFA);
    rd(2'd2, v); chk("R3 control keeps three bits", v, 32'd2);
    wr(2'd0, 32'hABCD_1234);
    rd(2'd0, v); chk("R2 start value readback", v, 32'h0000_1234);
    rd(2'd3, v); chk("R2 clear address reads zero", v, 32'd0);
    rd(2'd1, v); chk("R10 preload while stopped", v, 32'h0000_1234);
    wr(2'd2, 32'd0);

    for (int mode = 1; mode >= 0; mode--) begin
      for (int fast = 0; fast < 2; fast++) begin
        for (int n = 0; n < 6; n++) begin
          if (n == 4) continue;
          div = fast ? FDIV : SDIV;
          wr(2'd2, 32'd0);
          wr(2'd3, 32'd0);
          chk("R9 clear before config", {31'd0, irq}, 32'd0);
          wr(2'd0, n);
          rd(2'd1, v); chk("R10 preload value", v, n);
          wr(2'd2, {29'd0, fast[0], mode[0], 1'b1});
          wait_irq(ta);
          rd_and_clear(v);
          if (mode == 1) chk("R6 periodic reload value", v, n);
          else           chk("R7 free wrap value", v, 32'h0000_FFFF);
          chk("R9 irq cleared", {31'd0, irq}, 32'd0);
          if (mode == 1) begin
            wait_irq(tb);
            rd_and_clear(v);
            chk(fast ? "R5 R4 fast period" : "R5 R4 slow period", tb - ta, (n + 1) * div);
          end
        end
      end
    end

    wr(2'd2, 32'd0);
    wr(2'd3, 32'd0);
    wr(2'd0, 32'd40);
    wr(2'd2, 32'd3);
    repeat (30) @(negedge clk);
    wr(2'd2, 32'd0);
    rd(2'd1, v);
    repeat (50) @(negedge clk);
    rd(2'd1, v2);
    chk("R11 counter frozen when stopped", v2, v);
    chk("R5 counter moved while running", {31'd0, v < 32'd40}, 32'd1);

    wr(2'd0, 32'd0);
    wr(2'd2, 32'd3);
    wait_irq(ta);
    wr(2'd3, 32'hDEAD_BEEF);
    chk("R9 clear with nonzero data", {31'd0, irq}, 32'd0);
    repeat (6) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'd0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 set wins over same-edge clear", {31'd0, irq}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 irq sticky", {31'd0, irq}, 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule